// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-up to operating mode. After reset is released it counts out a 200 µs settling wait in system clock cycles, then walks the memory through its mandatory start-up command sequence. The block never drives the memory command pins itself: for each step it raises a request with a command code (and, for the register loads, a bank select and a register value) to a separate command issuer, and it waits for that issuer to report completion with a one-cycle done pulse.

Between the mode-register load that resets the DLL and the following precharge, the sequencer holds off for a fixed number of clock cycles so that the DLL can lock. When the final operating-mode load completes, `init_done` rises and stays high until the next reset. A reset in any state returns the block to its idle state and reruns the full wait and the full sequence. The CAS latency written into the mode register is set by a parameter.

Top module: `ddr_init_seq`

## Requirements
- R1: The first command request becomes visible exactly W rising clock edges after the first edge with reset low, where W is ceil(200000000 / CLK_PERIOD_PS) or WAIT_OVERRIDE when that parameter is nonzero; no request is raised before that.
- R2: Commands are requested in this order, using the codes 1 = precharge all banks, 2 = extended mode register load, 3 = mode register load, 4 = auto-refresh (0 = none): 1, 2, 3, 1, 4, 4, 3.
- R3: A request is held with an unchanged code and register value until `cmd_done` is sampled high with it; each done pulse advances exactly one step, and `cmd_done` while no request is raised has no effect.
- R4: After the DLL-reset mode load completes, `cmd_req` stays low for exactly DLL_WAIT_CYC cycles (default 200) before the second precharge is requested.
- R5: Register values: the extended load uses bank 1 and value 0 (DLL enabled); both mode loads use bank 0 with burst-length field bits [2:0] = 3'b001, burst type bit 3 = 0, CAS latency in bits [6:4]; bit 8 (DLL reset) is 1 in the first mode load and 0 in the second.
- R6: `init_done` rises in the cycle after the final mode load is acknowledged, then stays high with no further requests until reset, ignoring any `cmd_done`.
- R7: While reset is high, `cmd_req` and `init_done` are low; reset in any state restarts the full wait of R1 and the full sequence of R2.
- R8: The CAS latency field of R5 holds the CAS_LAT parameter, 2 or 3 (value 0x121/0x021 for 2, 0x131/0x031 for 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_done | input | 1 | One-cycle completion pulse from the command issuer |
| cmd_req | output | 1 | Command request to the issuer |
| cmd_code | output | 3 | Requested command code |
| mode_bank | output | BANK_W | Bank select for register loads |
| mode_value | output | ROW_W | Register value for register loads |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
On every cycle the assertions check that no request appears before the power-up wait has elapsed, that a pending request keeps its code until acknowledged, that the request drops after a DLL-reset load, that completion follows only the final mode load and is sticky, and that reset clears the outputs. The exact command order, the exact wait and DLL gap lengths, the register values for both CAS latencies, the rejection of stray done pulses, and the full restart after a reset in mid-sequence are only shown by the bench's scenarios.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_PRECHARGE = 3'd1,
        CMD_LOAD_EXT  = 3'd2,
        CMD_LOAD_MODE = 3'd3,
        CMD_REFRESH   = 3'd4
    } cmd_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE1,
        S_EMR,
        S_MR_RST,
        S_DLL_WAIT,
        S_PRE2,
        S_REF1,
        S_REF2,
        S_MR_OP,
        S_DONE
    } step_t;

    // Mode register field positions
    localparam int MR_BL_LSB  = 0;
    localparam int MR_CL_LSB  = 4;
    localparam int MR_DLL_BIT = 8;
    localparam logic [2:0] MR_BL_TWO = 3'b001;

    localparam int POWERUP_PS = 200_000_000;

    function automatic int power_up_cycles(input int period_ps);
        return (POWERUP_PS + period_ps - 1) / period_ps;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (count != CNT_MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ddr_init_decode.sv
module ddr_init_decode
    import ddr_init_pkg::*;
#(
    parameter int CAS_LAT = 2,
    parameter int ROW_W   = 13,
    parameter int BANK_W  = 2
) (
    input  step_t             step,
    output logic              req,
    output cmd_t              code,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  value
);
    logic [ROW_W-1:0] mode_base;

    always_comb begin
        mode_base = '0;
        mode_base[MR_BL_LSB +: 3] = MR_BL_TWO;
        mode_base[MR_CL_LSB +: 3] = 3'(CAS_LAT);
    end

    always_comb begin
        req   = 1'b1;
        code  = CMD_NONE;
        bank  = '0;
        value = '0;
        case (step)
            S_PRE1, S_PRE2: code = CMD_PRECHARGE;
            S_EMR: begin
                code = CMD_LOAD_EXT;
                bank = BANK_W'(1);
            end
            S_MR_RST: begin
                code  = CMD_LOAD_MODE;
                value = mode_base;
                value[MR_DLL_BIT] = 1'b1;
            end
            S_REF1, S_REF2: code = CMD_REFRESH;
            S_MR_OP: begin
                code  = CMD_LOAD_MODE;
                value = mode_base;
            end
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int WAIT_OVERRIDE = 0,
    parameter int DLL_WAIT_CYC  = 200,
    parameter int CAS_LAT       = 2,
    parameter int ROW_W         = 13,
    parameter int BANK_W        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_done,
    output logic              cmd_req,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] mode_bank,
    output logic [ROW_W-1:0]  mode_value,
    output logic              init_done
);
    localparam int WAIT_CYC = (WAIT_OVERRIDE > 0) ? WAIT_OVERRIDE
                                                  : power_up_cycles(CLK_PERIOD_PS);
    localparam int MAX_CYC  = (WAIT_CYC > DLL_WAIT_CYC) ? WAIT_CYC : DLL_WAIT_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] DLL_LAST  = CNT_W'(DLL_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_FULL = CNT_W'(WAIT_CYC);

    step_t            st, nx;
    cmd_t             code;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] age;

    ddr_init_timer #(.CNT_W(CNT_W)) u_step_timer (
        .clk(clk), .rst(rst), .clr(st != nx), .count(cnt)
    );

    ddr_init_timer #(.CNT_W(CNT_W)) u_age_timer (
        .clk(clk), .rst(rst), .clr(1'b0), .count(age)
    );

    ddr_init_decode #(.CAS_LAT(CAS_LAT), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_decode (
        .step(st), .req(cmd_req), .code(code), .bank(mode_bank), .value(mode_value)
    );

    assign cmd_code  = code;
    assign init_done = (st == S_DONE);

    always_comb begin
        nx = st;
        case (st)
            S_IDLE:     if (cnt == WAIT_LAST) nx = S_PRE1;
            S_PRE1:     if (cmd_done) nx = S_EMR;
            S_EMR:      if (cmd_done) nx = S_MR_RST;
            S_MR_RST:   if (cmd_done) nx = S_DLL_WAIT;
            S_DLL_WAIT: if (cnt == DLL_LAST) nx = S_PRE2;
            S_PRE2:     if (cmd_done) nx = S_REF1;
            S_REF1:     if (cmd_done) nx = S_REF2;
            S_REF2:     if (cmd_done) nx = S_MR_OP;
            S_MR_OP:    if (cmd_done) nx = S_DONE;
            default:    nx = st;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nx;
    end

    assert_no_early_req_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> (age >= WAIT_FULL));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_code) && $stable(mode_value)));

    assert_dll_gap_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmd_req) && !init_done) |-> $past(mode_value[MR_DLL_BIT]));

    assert_done_entry_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> ($past(cmd_done) && ($past(cmd_code) == CMD_LOAD_MODE)));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && !cmd_req));

    assert_reset_clear_R7: assert property (@(posedge clk)
        $past(rst) |-> (!cmd_req && !init_done));

endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
    localparam int CLK_PS   = 10;
    localparam int PERIOD   = 10000;
    localparam int W        = (200000000 + PERIOD - 1) / PERIOD;
    localparam int DLL      = 200;
    localparam int W3       = 8;
    localparam int ISSUE_D  = 2;
    localparam int LIMIT    = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic done_m = 1'b0;
    logic spur = 1'b0;
    logic cmd_done;
    logic cmd_req, init_done;
    logic [2:0] cmd_code;
    logic [1:0] mode_bank;
    logic [12:0] mode_value;

    logic req3, done3;
    logic [2:0] code3;
    logic [1:0] bank3;
    logic [12:0] val3;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [2:0]  lcode [0:15];
    logic [1:0]  lbank [0:15];
    logic [12:0] lval  [0:15];
    int nlog = 0;
    int gaps [0:7];
    int ngap = 0;
    int lowcnt = 0;
    int dly = 0;
    logic [2:0] held_code;
    int stable_bad = 0;
    logic [12:0] cl3_val [0:3];
    int ncl3 = 0;

    assign cmd_done = done_m | spur;

    always #(CLK_PS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr_init_seq #(.CLK_PERIOD_PS(PERIOD), .DLL_WAIT_CYC(DLL), .CAS_LAT(2)) u_dut (
        .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd_req(cmd_req),
        .cmd_code(cmd_code), .mode_bank(mode_bank), .mode_value(mode_value),
        .init_done(init_done)
    );

    assign done3 = req3;
    ddr_init_seq #(.CLK_PERIOD_PS(PERIOD), .WAIT_OVERRIDE(W3), .DLL_WAIT_CYC(4), .CAS_LAT(3)) u_dut_cl3 (
        .clk(clk), .rst(rst), .cmd_done(done3), .cmd_req(req3),
        .cmd_code(code3), .mode_bank(bank3), .mode_value(val3),
        .init_done()
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Command issuer model, low-run measurement, stray done pulses
    always @(negedge clk) begin
        if (rst) begin
            done_m <= 1'b0; dly <= 0; lowcnt <= 0; spur <= 1'b0;
            ncl3 <= 0;
        end else begin
            if (done_m) begin
                done_m <= 1'b0; dly <= 0;
            end else if (cmd_req) begin
                if (dly == 0) held_code <= cmd_code;
                else if (cmd_code != held_code) stable_bad <= stable_bad + 1;
                if (dly == ISSUE_D) begin
                    done_m <= 1'b1;
                    if (nlog < 16) begin
                        lcode[nlog] <= cmd_code; lbank[nlog] <= mode_bank; lval[nlog] <= mode_value;
                    end
                    nlog <= nlog + 1;
                end else dly <= dly + 1;
            end
            if (!cmd_req && !init_done) begin
                lowcnt <= lowcnt + 1;
                spur <= (lowcnt == 5);
            end else begin
                spur <= 1'b0;
                if (cmd_req && lowcnt > 0) begin
                    if (ngap < 8) gaps[ngap] <= lowcnt;
                    ngap <= ngap + 1;
                    lowcnt <= 0;
                end
            end
            if (req3 && code3 == 3'd3) begin
                if (ncl3 < 4) cl3_val[ncl3] <= val3;
                ncl3 <= ncl3 + 1;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); #1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(cmd_req == 1'b0, "R7 req low in reset", cmd_req, 0);
        check(init_done == 1'b0, "R7 done low in reset", init_done, 0);
        nlog = 0; ngap = 0; stable_bad = 0;
        #1 rst = 1'b0;
    endtask

    task automatic wait_done();
        while (!init_done && cyc < LIMIT) @(negedge clk);
    endtask

    task automatic check_run();
        logic [2:0] exp_code [0:6];
        exp_code[0] = 3'd1; exp_code[1] = 3'd2; exp_code[2] = 3'd3; exp_code[3] = 3'd1;
        exp_code[4] = 3'd4; exp_code[5] = 3'd4; exp_code[6] = 3'd3;
        check(nlog == 7, "R2 command count", nlog, 7);
        for (int i = 0; i < 7; i++)
            check(lcode[i] == exp_code[i], "R2 command order", lcode[i], exp_code[i]);
        check(stable_bad == 0, "R3 code held until done", stable_bad, 0);
        // first request after W edges: W-1 low samples at falling edges
        check(ngap == 2, "R4 low runs", ngap, 2);
        check(gaps[0] == W - 1, "R1 power-up wait", gaps[0], W - 1);
        check(gaps[1] == DLL, "R4 DLL wait", gaps[1], DLL);
        check(lbank[1] == 2'd1 && lval[1] == 13'h000, "R5 extended load", lval[1], 0);
        check(lbank[2] == 2'd0 && lval[2] == 13'h121, "R5 R8 DLL reset load", lval[2], 13'h121);
        check(lbank[6] == 2'd0 && lval[6] == 13'h021, "R5 R8 operating load", lval[6], 13'h021);
        check(init_done == 1'b1 && cmd_req == 1'b0, "R6 init_done", init_done, 1);
    endtask

    initial begin : watchdog
        while (cyc < LIMIT) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Run 1: full sequence, stray done pulses in both waits
        do_reset();
        wait_done();
        check_run();
        // R6: done stays, stray done ignored
        @(negedge clk); #1 spur = 1'b1;
        @(negedge clk); #1 spur = 1'b0;
        repeat (5) @(negedge clk);
        check(init_done == 1'b1, "R6 sticky after stray done", init_done, 1);
        check(cmd_req == 1'b0, "R6 R3 no request after done", cmd_req, 0);
        check(ncl3 == 2, "R8 CAS3 mode loads", ncl3, 2);
        check(cl3_val[0] == 13'h131, "R8 CAS3 DLL reset load", cl3_val[0], 13'h131);
        check(cl3_val[1] == 13'h031, "R8 CAS3 operating load", cl3_val[1], 13'h031);

        // Run 2: reset in mid-sequence after the first refresh was issued
        do_reset();
        while (nlog < 5 && cyc < LIMIT) @(negedge clk);
        do_reset();
        wait_done();
        check_run();
        check(lcode[0] == 3'd1, "R7 restart from first precharge", lcode[0], 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule